// File: doc/BRIEF.md
# Event Timer Global Control and Interrupt Router

This block is the shared control stage of a small multi-timer event unit. It holds a 64-bit global control register with two live bits, one that enables the whole unit and one that selects legacy-replacement routing. It advances a free-running 64-bit main counter only while the unit is enabled. It also turns the match pulses from each timer's comparator into interrupt requests. Each timer has a status bit that software clears by writing 1 to it. Each timer can be set for level or edge signalling, and each request is steered to one of 32 APIC inputs or to two fixed legacy controller lines.

Software reaches every register through one single-cycle register port. The address map is: 0 for global control, 1 for timer status, 2 for the main counter, and 4+n for the configuration of timer n. The comparators read `main_count` and send back one match pulse per timer.

Top module: `evt_timer_route`

## Requirements
- R1: After reset, global control, status, main counter and all timer configurations read as zero, and every interrupt output is low.
- R2: Control register (address 0) bit 0 is the global enable and bit 1 is legacy routing. Writes to bits 63:2 are dropped, and those bits always read 0.
- R3: While the global enable is 1 the main counter grows by exactly one per clock. While it is 0 the counter holds.
- R4: A write to address 2 loads the counter only while the global enable is 0. While enabled, such a write is ignored.
- R5: Status bit n (address 1) sets in the cycle after a match on timer n when both the global enable and the timer enable are 1. Writing 1 to a bit clears it, and writing 0 leaves it alone. A match in the same cycle as a clear leaves the bit set.
- R6: A level-mode timer drives its line while its status bit is set, its timer enable is 1 and the global enable is 1. Turning off the global enable drops the line but keeps the status bit, and turning it back on raises the line again.
- R7: An edge-mode timer drives its line for exactly one clock, in the cycle after each counted match.
- R8: While the global enable is 0, matches set no status and no interrupt output is high.
- R9: Timer configuration (address 4+n) holds bit 0 as the timer enable, bit 1 as level (1) or edge (0), and bits 6:2 as the APIC input number. With legacy routing off, each timer drives only APIC input equal to its route field, and both legacy lines stay low.
- R10: With the global enable and legacy routing both set, timer 0 drives legacy line 0 and APIC input 2, and timer 1 drives legacy line 8 and APIC input 8. The route fields of timers 0 and 1 have no effect in this mode.
- R11: Timers 2 and above always use their own route field, whatever the legacy routing bit is set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr` |
| tmr_match | input | 3 | One match pulse per timer from the comparators |
| main_count | output | 64 | Main counter value |
| pic_irq0 | output | 1 | Legacy controller line 0 |
| pic_irq8 | output | 1 | Legacy controller line 8 |
| apic_irq | output | 32 | APIC interrupt inputs |

## Verification
The hardest state to reach is a level interrupt left pending across a global disable. To get there, the bench first raises the status bit with a match while the unit is enabled, then clears the enable. It then confirms that the line drops while the status read-back still shows the bit, and that re-enabling raises the line again. A match landing in the same clock as a software clear also needs exact timing, so the bench drives both on one negedge. A table of routing vectors steps through legacy and non-legacy modes. In legacy mode the route fields of timers 0 and 1 are set to decoy values, so that any leak onto those APIC inputs shows up.

// File: rtl/evt_timer_route.sv
module evt_timer_route #(
  parameter int NUM_TMR = 3,
  parameter int CNT_W   = 64,
  parameter int ROUTE_W = 5,
  parameter int ADDR_W  = 4,
  localparam int NUM_APIC = 1 << ROUTE_W,
  localparam int CFG_W    = ROUTE_W + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [63:0]         reg_wdata,
  output logic [63:0]         reg_rdata,
  input  logic [NUM_TMR-1:0]  tmr_match,
  output logic [CNT_W-1:0]    main_count,
  output logic                pic_irq0,
  output logic                pic_irq8,
  output logic [NUM_APIC-1:0] apic_irq
);
  localparam int TMR_BASE = 4;

  logic               gen_en, leg_en;
  logic [CNT_W-1:0]   cnt_q;
  logic [NUM_TMR-1:0] sts_q, edge_q, ten, lvl, line, set_v, clr_v;
  logic [CFG_W-1:0]   tcfg_q [NUM_TMR];

  wire sel_gen = reg_wr && reg_addr == ADDR_W'(0);
  wire sel_sts = reg_wr && reg_addr == ADDR_W'(1);
  wire sel_cnt = reg_wr && reg_addr == ADDR_W'(2);
  wire legacy  = gen_en && leg_en;

  assign clr_v = sel_sts ? reg_wdata[NUM_TMR-1:0] : '0;
  assign set_v = tmr_match & ten & {NUM_TMR{gen_en}};
  assign main_count = cnt_q;

  for (genvar n = 0; n < NUM_TMR; n++) begin : g_tmr
    assign ten[n]  = tcfg_q[n][0];
    assign lvl[n]  = tcfg_q[n][1];
    assign line[n] = gen_en && ten[n] && (lvl[n] ? sts_q[n] : edge_q[n]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) tcfg_q[n] <= '0;
      else if (reg_wr && reg_addr == ADDR_W'(TMR_BASE + n)) tcfg_q[n] <= reg_wdata[CFG_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      gen_en <= 1'b0;
      leg_en <= 1'b0;
      cnt_q  <= '0;
      sts_q  <= '0;
      edge_q <= '0;
    end else begin
      if (sel_gen) {leg_en, gen_en} <= reg_wdata[1:0];
      if (gen_en) cnt_q <= cnt_q + 1'b1;
      else if (sel_cnt) cnt_q <= reg_wdata[CNT_W-1:0];
      sts_q  <= (sts_q & ~clr_v) | set_v;
      edge_q <= set_v;
    end

  assign pic_irq0 = legacy && line[0];
  assign pic_irq8 = legacy && line[1];

  always_comb begin
    apic_irq = '0;
    for (int n = 0; n < NUM_TMR; n++)
      if (!(legacy && n < 2) && line[n]) apic_irq[tcfg_q[n][CFG_W-1:2]] = 1'b1;
    if (legacy && line[0]) apic_irq[2] = 1'b1;
    if (legacy && line[1]) apic_irq[8] = 1'b1;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_W'(0): reg_rdata[1:0] = {leg_en, gen_en};
      ADDR_W'(1): reg_rdata[NUM_TMR-1:0] = sts_q;
      ADDR_W'(2): reg_rdata[CNT_W-1:0] = cnt_q;
      default:
        for (int n = 0; n < NUM_TMR; n++)
          if (reg_addr == ADDR_W'(TMR_BASE + n)) reg_rdata[CFG_W-1:0] = tcfg_q[n];
    endcase
  end
endmodule

module evt_timer_route_chk #(
  parameter int NUM_TMR  = 3,
  parameter int CNT_W    = 64,
  parameter int NUM_APIC = 32,
  parameter int ADDR_W   = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                reg_wr,
  input logic [ADDR_W-1:0]   reg_addr,
  input logic [63:0]         reg_wdata,
  input logic [63:0]         reg_rdata,
  input logic                gen_en,
  input logic                leg_en,
  input logic [NUM_TMR-1:0]  sts_q,
  input logic [CNT_W-1:0]    main_count,
  input logic                pic_irq0,
  input logic                pic_irq8,
  input logic [NUM_APIC-1:0] apic_irq
);
  wire cnt_wr = reg_wr && reg_addr == ADDR_W'(2);
  wire [NUM_TMR-1:0] clr_mask = (reg_wr && reg_addr == ADDR_W'(1)) ? reg_wdata[NUM_TMR-1:0] : '0;

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    gen_en |=> main_count == $past(main_count) + 1'b1);
  assert_cnt_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && !cnt_wr) |=> $stable(main_count));
  assert_cnt_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_en && cnt_wr) |=> main_count == $past(reg_wdata[CNT_W-1:0]));
  assert_quiet_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |-> (!pic_irq0 && !pic_irq8 && apic_irq == '0));
  assert_no_set_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !gen_en |=> (sts_q & ~$past(sts_q)) == '0);
  assert_sts_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(sts_q) & ~$past(clr_mask) & ~sts_q) == '0);
  assert_pic_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !leg_en |-> (!pic_irq0 && !pic_irq8));
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == ADDR_W'(0) |-> reg_rdata[63:2] == '0);
endmodule

bind evt_timer_route evt_timer_route_chk #(
  .NUM_TMR(NUM_TMR), .CNT_W(CNT_W), .NUM_APIC(NUM_APIC), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gen_en(gen_en),
  .leg_en(leg_en), .sts_q(sts_q), .main_count(main_count),
  .pic_irq0(pic_irq0), .pic_irq8(pic_irq8), .apic_irq(apic_irq)
);

// File: tb/evt_timer_route_tb.sv
`timescale 1ns/1ps
module evt_timer_route_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic [2:0]  tmr_match = '0;
  logic [63:0] main_count;
  logic        pic_irq0, pic_irq8;
  logic [31:0] apic_irq;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_timer_route dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tmr_match(tmr_match),
    .main_count(main_count), .pic_irq0(pic_irq0), .pic_irq8(pic_irq8),
    .apic_irq(apic_irq)
  );

  // {legacy, timer, route field, exp pic0, exp pic8, exp apic input}
  localparam logic [14:0] VEC [7] = '{
    {1'b0, 2'd0, 5'd5,  1'b0, 1'b0, 5'd5},
    {1'b0, 2'd1, 5'd17, 1'b0, 1'b0, 5'd17},
    {1'b0, 2'd2, 5'd31, 1'b0, 1'b0, 5'd31},
    {1'b1, 2'd0, 5'd5,  1'b1, 1'b0, 5'd2},
    {1'b1, 2'd1, 5'd17, 1'b0, 1'b1, 5'd8},
    {1'b1, 2'd2, 5'd9,  1'b0, 1'b0, 5'd9},
    {1'b0, 2'd0, 5'd2,  1'b0, 1'b0, 5'd2}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [2:0] m);
    @(negedge clk);
    tmr_match = m;
    @(negedge clk);
    tmr_match = '0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] d, c0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(4'(a), d);
      chk(d == 0, "R1 reset readback", d, 0);
    end
    chk({pic_irq0, pic_irq8, apic_irq} == 0, "R1 reset outputs", {pic_irq0, pic_irq8, apic_irq}, 0);

    // R2 reserved bits
    wr(0, 64'hFFFF_FFFF_FFFF_FFFE);
    rd(0, d);
    chk(d == 64'h2, "R2 reserved dropped", d, 64'h2);
    wr(0, 0);

    // R4 load while disabled, R3 hold
    wr(2, 64'h123);
    chk(main_count == 64'h123, "R4 load when disabled", main_count, 64'h123);
    repeat (3) @(negedge clk);
    chk(main_count == 64'h123, "R3 hold when disabled", main_count, 64'h123);

    // R3 step, R4 ignored write
    wr(0, 1);
    c0 = main_count;
    @(negedge clk);
    chk(main_count == c0 + 1, "R3 step when enabled", main_count, c0 + 1);
    c0 = main_count;
    wr(2, 64'hAAAA);
    chk(main_count == c0 + 2, "R4 write ignored when enabled", main_count, c0 + 2);

    // R9 R10 R11 routing table (level mode)
    for (int i = 0; i < 7; i++) begin
      logic [14:0] v;
      v = VEC[i];
      wr(0, {62'd0, v[14], 1'b1});
      wr(4'(4 + v[13:12]), {57'd0, v[11:7], 2'b11});
      pulse(3'(1 << v[13:12]));
      chk(pic_irq0 == v[6], "R10 legacy line 0", 64'(pic_irq0), 64'(v[6]));
      chk(pic_irq8 == v[5], "R10 legacy line 8", 64'(pic_irq8), 64'(v[5]));
      chk(apic_irq == (32'd1 << v[4:0]), v[13:12] == 2 ? "R11 timer2 route" : "R9 apic route",
          64'(apic_irq), 64'(32'd1 << v[4:0]));
      wr(1, '1);
    end

    // R7 edge mode pulse
    wr(0, 1);
    wr(4, {57'd0, 5'd4, 2'b01});
    pulse(3'b001);
    chk(apic_irq == 32'h10, "R7 edge pulse high", 64'(apic_irq), 64'h10);
    @(negedge clk);
    chk(apic_irq == 0, "R7 edge pulse one clock", 64'(apic_irq), 0);
    wr(1, '1);

    // R6 level survives disable
    wr(5, {57'd0, 5'd12, 2'b11});
    pulse(3'b010);
    chk(apic_irq == 32'h1000, "R6 level asserted", 64'(apic_irq), 64'h1000);
    wr(0, 0);
    chk(apic_irq == 0, "R6 line drops when disabled", 64'(apic_irq), 0);
    rd(1, d);
    chk(d[1] == 1'b1, "R6 status kept over disable", d, 64'h2);
    wr(0, 1);
    chk(apic_irq == 32'h1000, "R6 line returns", 64'(apic_irq), 64'h1000);

    // R5 write 0 no effect, write 1 clears
    wr(1, 0);
    rd(1, d);
    chk(d == 64'h2, "R5 write zero keeps", d, 64'h2);
    wr(1, 64'h2);
    rd(1, d);
    chk(d == 0, "R5 write one clears", d, 0);
    chk(apic_irq == 0, "R5 line off after clear", 64'(apic_irq), 0);

    // R5 match and clear together
    wr(4, {57'd0, 5'd3, 2'b11});
    @(negedge clk);
    tmr_match = 3'b001; reg_wr = 1'b1; reg_addr = 4'd1; reg_wdata = 64'h1;
    @(negedge clk);
    tmr_match = '0; reg_wr = 1'b0; reg_wdata = '0;
    rd(1, d);
    chk(d == 64'h1, "R5 match beats clear", d, 64'h1);
    wr(1, '1);

    // R8 matches ignored while disabled
    wr(0, 0);
    pulse(3'b111);
    rd(1, d);
    chk(d == 0, "R8 no status when disabled", d, 0);
    chk({pic_irq0, pic_irq8, apic_irq} == 0, "R8 outputs quiet", {pic_irq0, pic_irq8, apic_irq}, 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule